// File: doc/BRIEF.md
# Speculative Load Conflict Tracker

This block lets a processor move a load ahead of stores whose addresses are not yet known to differ from the load's address. When a load flagged for data speculation completes, the tracker stores the load's destination register number and its address in a small fully associative table. Every store that follows compares its address against all live entries. When a store hits the same 8-byte doubleword, the matching entry is marked as conflicted.

At the point where the load originally sat in program order, a check operation names the destination register. One cycle later the tracker answers with a response strobe. The response carries a conflict flag that is high when recovery is needed. The check always frees the entry it names. The tracker is conservative: a register that has no entry always reports a conflict. This covers entries that were evicted to make room, so no check ever misses a real dependence.

Top module: `spec_load_tracker`

## Requirements
- R1: A load with `ld_spec` low allocates nothing. A later check on its register reports a conflict, because the register has no entry.
- R2: A speculative load records its register and address. A check on that register, with no matching store in between, reports `chk_conflict` = 0.
- R3: A store whose address has the same bits [31:3] as a live entry's address marks that entry conflicted. This holds whatever the low three bits are. The entry's check then reports `chk_conflict` = 1.
- R4: A store to a different doubleword leaves the entry clean.
- R5: `chk_resp_valid` is high in exactly the cycle after a cycle with `chk_valid` high, and low otherwise. `chk_conflict` is valid alongside it.
- R6: A check frees the entry it names. A second check on the same register reports a conflict.
- R7: A check on a register with no entry reports a conflict.
- R8: A speculative load to a register that already has an entry overwrites that entry. It takes the new address, clears the conflict mark and becomes the youngest entry.
- R9: When all 8 entries are live and a speculative load names a new register, the least recently allocated entry is replaced. A check on the replaced register then reports a conflict. The other entries are unaffected.
- R10: When a store and a check for a matching entry occur in the same cycle, the store is applied first, so the check reports a conflict.
- R11: After reset the table is empty and `chk_resp_valid` is low.
- R12: Same-cycle ordering is store, then check, then load allocation. A check and a load on the same register in one cycle answer from the old entry and leave a fresh clean entry. A store and a load to the same doubleword in one cycle leave the new entry clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | A load completes this cycle |
| ld_spec | input | 1 | The completing load is data-speculative |
| ld_reg | input | 7 | Destination register of the load |
| ld_addr | input | 32 | Byte address read by the load |
| st_valid | input | 1 | A store is performed this cycle |
| st_addr | input | 32 | Byte address written by the store |
| chk_valid | input | 1 | A check operation is issued this cycle |
| chk_reg | input | 7 | Register named by the check |
| chk_resp_valid | output | 1 | Check response strobe, one cycle after the check |
| chk_conflict | output | 1 | High when the checked load needs recovery |

## Verification
The bench targets doubleword matching at its edges: a store at byte offset 7 of the load's doubleword must conflict, and a store in the next doubleword must not. Getting the compared bit range wrong breaks one of these two cases. It also covers the same-cycle orderings. A design that applied the check before the store would report a clean check that should conflict. A design that let a freed or overwritten entry linger would report a stale conflict after a reload. Replacement is checked after an overwrite has changed the age order. An age tracker that ignores refreshes would evict the refreshed register instead of the truly oldest one.

// File: rtl/slt_pkg.sv
package slt_pkg;

    // Registered answer to a check operation
    typedef struct packed {
        logic done;
        logic conflict;
    } chk_resp_t;

endpackage

// File: rtl/slt_addr_cam.sv
module slt_addr_cam #(
    parameter int unsigned N        = 8,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned GRAN_LSB = 3
) (
    input  logic [N-1:0]             ent_vld,
    input  logic [N-1:0][ADDR_W-1:0] ent_addr,
    input  logic                     probe_valid,
    input  logic [ADDR_W-1:0]        probe_addr,
    output logic [N-1:0]             probe_hit
);

    // One comparator per entry; only the doubleword part of the address is compared
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign probe_hit[i] = probe_valid && ent_vld[i] &&
                              (ent_addr[i][ADDR_W-1:GRAN_LSB] == probe_addr[ADDR_W-1:GRAN_LSB]);
    end

endmodule

// File: rtl/slt_reg_lookup.sv
module slt_reg_lookup #(
    parameter int unsigned N     = 8,
    parameter int unsigned REG_W = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            ent_vld,
    input  logic [N-1:0][REG_W-1:0] ent_reg,
    input  logic [REG_W-1:0]        chk_reg,
    input  logic [REG_W-1:0]        ld_reg,
    output logic [N-1:0]            chk_hit,
    output logic [N-1:0]            ld_hit
);

    for (genvar i = 0; i < N; i++) begin : g_tag
        assign chk_hit[i] = ent_vld[i] && (ent_reg[i] == chk_reg);
        assign ld_hit[i]  = ent_vld[i] && (ent_reg[i] == ld_reg);
    end

    // Overwrite-on-reload keeps at most one entry per register
    AST_ONE_ENTRY_PER_REG: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chk_hit) && $onehot0(ld_hit)); // R8

endmodule

// File: rtl/slt_victim_sel.sv
module slt_victim_sel #(
    parameter int unsigned N     = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N-1:0]            ent_vld,
    input  logic [N-1:0][IDX_W-1:0] ent_rank,
    output logic                    any_free,
    output logic [IDX_W-1:0]        free_idx,
    output logic [IDX_W-1:0]        old_idx
);

    logic [N-1:0] is_oldest;

    for (genvar i = 0; i < N; i++) begin : g_old
        assign is_oldest[i] = ent_vld[i] && (ent_rank[i] == IDX_W'(N-1));
    end

    always_comb begin
        any_free = ~&ent_vld;
        free_idx = '0;
        old_idx  = '0;
        for (int i = N-1; i >= 0; i--) begin
            if (!ent_vld[i]) free_idx = IDX_W'(i);
            if (is_oldest[i]) old_idx = IDX_W'(i);
        end
    end

    // A full table has exactly one least recently allocated entry
    AST_SINGLE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        !any_free |-> $countones(is_oldest) == 1); // R9

endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker
    import slt_pkg::*;
#(
    parameter int unsigned N        = 8,
    parameter int unsigned REG_W    = 7,
    parameter int unsigned ADDR_W   = 32,
    parameter int unsigned GRAN_LSB = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_valid,
    input  logic              ld_spec,
    input  logic [REG_W-1:0]  ld_reg,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic              chk_valid,
    input  logic [REG_W-1:0]  chk_reg,
    output logic              chk_resp_valid,
    output logic              chk_conflict
);

    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [N-1:0]             vld;
        logic [N-1:0]             conf;
        logic [N-1:0][REG_W-1:0]  regs;
        logic [N-1:0][ADDR_W-1:0] addr;
        logic [N-1:0][IDX_W-1:0]  rank;   // 0 = youngest allocation
        chk_resp_t                resp;
    } state_t;

    state_t st_d, st_q;

    logic [N-1:0]            st_hit;
    logic [N-1:0]            chk_hit;
    logic [N-1:0]            ld_hit;
    logic [N-1:0]            chk_free;
    logic [N-1:0]            vld_mid;
    logic [N-1:0]            conf_mid;
    logic [N-1:0][IDX_W-1:0] rank_mid;
    logic [IDX_W-1:0]        freed_rank;
    logic                    any_free;
    logic [IDX_W-1:0]        free_idx;
    logic [IDX_W-1:0]        old_idx;
    logic [N-1:0]            alloc_oh;

    slt_addr_cam #(
        .N(N), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB)
    ) i_cam (
        .ent_vld    (st_q.vld),
        .ent_addr   (st_q.addr),
        .probe_valid(st_valid),
        .probe_addr (st_addr),
        .probe_hit  (st_hit)
    );

    slt_reg_lookup #(
        .N(N), .REG_W(REG_W)
    ) i_lookup (
        .clk    (clk),
        .rst_n  (rst_n),
        .ent_vld(st_q.vld),
        .ent_reg(st_q.regs),
        .chk_reg(chk_reg),
        .ld_reg (ld_reg),
        .chk_hit(chk_hit),
        .ld_hit (ld_hit)
    );

    // Step 1 and 2 of the same-cycle order: store marks, then the check frees
    always_comb begin
        conf_mid   = st_q.conf | st_hit;
        chk_free   = chk_valid ? chk_hit : '0;
        vld_mid    = st_q.vld & ~chk_free;
        freed_rank = '0;
        for (int i = 0; i < N; i++) begin
            if (chk_free[i]) freed_rank = freed_rank | st_q.rank[i];
        end
        rank_mid = st_q.rank;
        for (int i = 0; i < N; i++) begin
            if (vld_mid[i] && (|chk_free) && (st_q.rank[i] > freed_rank)) begin
                rank_mid[i] = st_q.rank[i] - IDX_W'(1);
            end
        end
    end

    slt_victim_sel #(
        .N(N), .IDX_W(IDX_W)
    ) i_victim (
        .clk     (clk),
        .rst_n   (rst_n),
        .ent_vld (vld_mid),
        .ent_rank(rank_mid),
        .any_free(any_free),
        .free_idx(free_idx),
        .old_idx (old_idx)
    );

    // Next-state computation: check response, then load allocation
    always_comb begin
        logic [N-1:0]     ld_live;
        logic [IDX_W-1:0] tgt;
        logic [IDX_W-1:0] tgt_rank;

        st_d      = st_q;
        st_d.vld  = vld_mid;
        st_d.conf = conf_mid;
        st_d.rank = rank_mid;

        st_d.resp.done     = chk_valid;
        st_d.resp.conflict = chk_valid && (!(|chk_hit) || (|(chk_hit & conf_mid)));

        ld_live  = ld_hit & vld_mid;
        tgt      = '0;
        tgt_rank = IDX_W'(N-1);
        alloc_oh = '0;
        if (ld_valid && ld_spec) begin
            if (|ld_live) begin
                for (int i = 0; i < N; i++) begin
                    if (ld_live[i]) begin
                        tgt      = IDX_W'(i);
                        tgt_rank = rank_mid[i];
                    end
                end
            end else if (any_free) begin
                tgt = free_idx;
            end else begin
                tgt = old_idx;
            end
            for (int i = 0; i < N; i++) begin
                if (IDX_W'(i) == tgt) begin
                    alloc_oh[i]     = 1'b1;
                    st_d.vld[i]     = 1'b1;
                    st_d.conf[i]    = 1'b0;
                    st_d.regs[i]    = ld_reg;
                    st_d.addr[i]    = ld_addr;
                    st_d.rank[i]    = '0;
                end else if (vld_mid[i] && (rank_mid[i] < tgt_rank)) begin
                    st_d.rank[i]    = rank_mid[i] + IDX_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign chk_resp_valid = st_q.resp.done;
    assign chk_conflict   = st_q.resp.conflict;

    AST_RESP_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid |=> chk_resp_valid); // R5
    AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid |=> !chk_resp_valid); // R5
    AST_MISS_IS_CONFLICT: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid && !(|chk_hit) |=> chk_conflict); // R7
    AST_NONSPEC_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_valid && ld_spec) && !chk_valid |=> $stable(st_q.vld)); // R1

    for (genvar i = 0; i < N; i++) begin : g_ast
        AST_STORE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
            st_hit[i] && !chk_free[i] && !alloc_oh[i] |=> st_q.conf[i]); // R3
    end

endmodule

// File: tb/test_spec_load_tracker.sv
module test_spec_load_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_valid = 1'b0;
    logic        ld_spec = 1'b0;
    logic [6:0]  ld_reg = '0;
    logic [31:0] ld_addr = '0;
    logic        st_valid = 1'b0;
    logic [31:0] st_addr = '0;
    logic        chk_valid = 1'b0;
    logic [6:0]  chk_reg = '0;
    logic        chk_resp_valid;
    logic        chk_conflict;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;   // 250 MHz

    spec_load_tracker i_spec_load_tracker (
        .clk(clk), .rst_n(rst_n),
        .ld_valid(ld_valid), .ld_spec(ld_spec), .ld_reg(ld_reg), .ld_addr(ld_addr),
        .st_valid(st_valid), .st_addr(st_addr),
        .chk_valid(chk_valid), .chk_reg(chk_reg),
        .chk_resp_valid(chk_resp_valid), .chk_conflict(chk_conflict)
    );

    typedef struct packed {
        logic        ld_v;
        logic        ld_s;
        logic [6:0]  ld_r;
        logic [31:0] ld_a;
        logic        st_v;
        logic [31:0] st_a;
        logic        ck_v;
        logic [6:0]  ck_r;
        logic        exp_conf;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b1,7'd5, 32'h1000,1'b0,32'h0,   1'b0,7'd0, 1'b0,4'd2},  // R2 alloc
        '{1'b0,1'b0,7'd0, 32'h0,   1'b0,32'h0,   1'b1,7'd5, 1'b0,4'd2},  // R2 clean
        '{1'b0,1'b0,7'd0, 32'h0,   1'b0,32'h0,   1'b1,7'd5, 1'b1,4'd6},  // R6 freed
        '{1'b1,1'b0,7'd6, 32'h2000,1'b0,32'h0,   1'b0,7'd0, 1'b0,4'd1},  // R1 plain load
        '{1'b0,1'b0,7'd0, 32'h0,   1'b0,32'h0,   1'b1,7'd6, 1'b1,4'd1},  // R1
        '{1'b1,1'b1,7'd7, 32'h3000,1'b0,32'h0,   1'b0,7'd0, 1'b0,4'd3},  // R3
        '{1'b0,1'b0,7'd0, 32'h0,   1'b1,32'h3007,1'b0,7'd0, 1'b0,4'd3},  // R3 offset 7
        '{1'b0,1'b0,7'd0, 32'h0,   1'b0,32'h0,   1'b1,7'd7, 1'b1,4'd3},  // R3
        '{1'b1,1'b1,7'd8, 32'h4000,1'b0,32'h0,   1'b0,7'd0, 1'b0,4'd4},  // R4
        '{1'b0,1'b0,7'd0, 32'h0,   1'b1,32'h4008,1'b0,7'd0, 1'b0,4'd4},  // R4 next dword
        '{1'b0,1'b0,7'd0, 32'h0,   1'b0,32'h0,   1'b1,7'd8, 1'b0,4'd4},  // R4
        '{1'b0,1'b0,7'd0, 32'h0,   1'b0,32'h0,   1'b1,7'd99,1'b1,4'd7},  // R7
        '{1'b1,1'b1,7'd9, 32'h5000,1'b0,32'h0,   1'b0,7'd0, 1'b0,4'd8},  // R8
        '{1'b0,1'b0,7'd0, 32'h0,   1'b1,32'h5004,1'b0,7'd0, 1'b0,4'd8},  // R8 mark
        '{1'b1,1'b1,7'd9, 32'h5000,1'b0,32'h0,   1'b0,7'd0, 1'b0,4'd8},  // R8 reload
        '{1'b0,1'b0,7'd0, 32'h0,   1'b0,32'h0,   1'b1,7'd9, 1'b0,4'd8},  // R8 clean
        '{1'b1,1'b1,7'd10,32'h6000,1'b0,32'h0,   1'b0,7'd0, 1'b0,4'd10}, // R10
        '{1'b0,1'b0,7'd0, 32'h0,   1'b1,32'h6000,1'b1,7'd10,1'b1,4'd10}, // R10 same cycle
        '{1'b1,1'b1,7'd11,32'h7000,1'b0,32'h0,   1'b0,7'd0, 1'b0,4'd12}, // R12
        '{1'b1,1'b1,7'd11,32'h7100,1'b0,32'h0,   1'b1,7'd11,1'b0,4'd12}, // R12 check+load
        '{1'b0,1'b0,7'd0, 32'h0,   1'b0,32'h0,   1'b1,7'd11,1'b0,4'd12}, // R12 fresh entry
        '{1'b1,1'b1,7'd12,32'h8000,1'b1,32'h8000,1'b0,7'd0, 1'b0,4'd12}, // R12 store+load
        '{1'b0,1'b0,7'd0, 32'h0,   1'b0,32'h0,   1'b1,7'd12,1'b0,4'd12}  // R12
    };

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s resp/conflict actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        ld_valid = 1'b0; ld_spec = 1'b0; st_valid = 1'b0; chk_valid = 1'b0;
    endtask

    task automatic spec_load(input logic [6:0] r, input logic [31:0] a);
        ld_valid = 1'b1; ld_spec = 1'b1; ld_reg = r; ld_addr = a;
        step();
        idle();
    endtask

    task automatic check_reg(input logic [6:0] r, input logic exp, input string req);
        chk_valid = 1'b1; chk_reg = r;
        step();
        idle();
        check(req, {chk_resp_valid, chk_conflict}, {1'b1, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", {chk_resp_valid, chk_conflict}, 2'b00);
        rst_n = 1'b1;
        step();
        check("R11", {chk_resp_valid, chk_conflict}, 2'b00);
        check_reg(7'd5, 1'b1, "R11");

        // Vector table: R1..R8, R10, R12, and R5 on every vector
        for (int v = 0; v < NV; v++) begin
            ld_valid = VECS[v].ld_v; ld_spec = VECS[v].ld_s;
            ld_reg = VECS[v].ld_r; ld_addr = VECS[v].ld_a;
            st_valid = VECS[v].st_v; st_addr = VECS[v].st_a;
            chk_valid = VECS[v].ck_v; chk_reg = VECS[v].ck_r;
            step();
            idle();
            check($sformatf("R%0d/R5 vec %0d", VECS[v].req, v),
                  {chk_resp_valid, chk_conflict},
                  VECS[v].ck_v ? {1'b1, VECS[v].exp_conf} : 2'b00);
        end

        // R9: fill, refresh reg 20, then overflow evicts reg 21
        for (int k = 0; k < 8; k++) spec_load(7'(20 + k), 32'(32'h100 * (k + 1)));
        spec_load(7'd20, 32'h900);
        spec_load(7'd28, 32'hA00);
        check_reg(7'd21, 1'b1, "R9 evicted");
        check_reg(7'd20, 1'b0, "R9 refreshed kept");
        for (int k = 22; k < 29; k++) check_reg(7'(k), 1'b0, "R9 survivor");

        // R11: reset clears live entries
        spec_load(7'd30, 32'hB00);
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
        step();
        check_reg(7'd30, 1'b1, "R11 cleared");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule